// File: doc/BRIEF.md
# SPI Register-Access Master

This block is a single-channel serial master that reaches a register-mapped slave over a four-wire SPI link. A fast system clock runs all of its logic. A half-period counter divides that clock into a slow serial clock, and the serial clock is itself a register output. All edge timing therefore stays in the system-clock domain.

A one-cycle start pulse launches a framed transaction. The frame carries a direction bit (0 means write, 1 means read), then a register address, then a data byte. Each field is sent most significant bit first. During a read frame the slave returns the addressed register in the data phase, and the master collects those bits. After a read frame ends, the collected byte appears on a parallel output together with a one-cycle valid strobe. A write frame leaves the output and the strobe untouched.

The divide ratio and the field widths are parameters. The defaults are a 40:1 ratio, a 7-bit address and an 8-bit data byte, so a frame is 16 bits long.

Top module: `spi_regacc_master`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `cs_n_o` is 1, `sclk_o` is 0, `mosi_o` is 0, `rd_valid_o` is 0 and `rd_byte_o` is 0.
- R2: `sclk_o` is 0 in every cycle in which `cs_n_o` is 1.
- R3: A start pulse seen while idle drives `cs_n_o` low after that clock edge. The first rising edge of `sclk_o` follows DIV_RATIO/2 cycles after `cs_n_o` falls.
- R4: `sclk_o` has a period of DIV_RATIO cycles. A frame contains exactly 1+ADDR_W+DATA_W rising edges. `cs_n_o` stays low for exactly (2*(1+ADDR_W+DATA_W)+1)*DIV_RATIO/2 cycles, so the release comes half a serial period after the last falling edge.
- R5: On `mosi_o` the frame is the direction bit (`op_read_i`, 1 for read), then `addr_i` from its top bit down, then `wr_byte_i` from its top bit down. These are the values captured with the start pulse. `mosi_o` changes only at frame start, at a falling edge of `sclk_o`, or at release.
- R6: In a read frame, `miso_i` is sampled at the rising edges of the last DATA_W serial clocks. The first sample is the top bit, and the result appears on `rd_byte_o`.
- R7: `rd_valid_o` is high for exactly one cycle per read frame, in the cycle in which `cs_n_o` returns high.
- R8: After a write frame, `rd_valid_o` has not pulsed and `rd_byte_o` still holds the last value read.
- R9: A start pulse that arrives while a frame is in progress has no effect. This includes a pulse in the frame's final cycle. No second frame starts and the running frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a frame |
| op_read_i | input | 1 | Direction of the requested frame: 1 read, 0 write |
| addr_i | input | ADDR_W | Register address sent in the frame |
| wr_byte_i | input | DATA_W | Data byte sent in the data phase |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| rd_byte_o | output | DATA_W | Byte collected by the last read frame |
| rd_valid_o | output | 1 | One-cycle strobe marking a new `rd_byte_o` |

## Verification
Two events can land on the same clock edge: the end of a frame, and a new start pulse. At that edge the chip select rises and the read strobe fires. The bench provokes this overlap directly. It counts cycles from the observed chip-select fall and places a start pulse exactly on the closing edge of a read frame. It then judges three things: the strobe still fires exactly once with the correct byte, the chip select stays high afterwards, and no second frame is ever counted. A separate case places a start pulse in the middle of a frame. Both cases run inside a full sweep of data bytes and addresses with the serial clock divided by 4.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_TAIL = 2'd3
   } phase_t;

   function automatic int unsigned frame_bits(input int unsigned aw, input int unsigned dw);
      return 1 + aw + dw;
   endfunction

endpackage

// File: rtl/spi_regacc_div.sv
module spi_regacc_div #(
   parameter int unsigned HALF = 20
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R4

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/spi_regacc_seq.sv
module spi_regacc_seq
   import spi_regacc_pkg::*;
#(
   parameter int unsigned FRAME = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic op_read,
   input  logic tick,
   output logic busy,
   output logic load,
   output logic sample_rx,
   output logic shift_tx,
   output logic finish,
   output logic commit,
   output logic sclk,
   output logic cs_n
);
   localparam int unsigned BW = $clog2(FRAME + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME);

   phase_t        ph_q, ph_d;
   logic [BW-1:0] bits_q;
   logic          rd_q;
   logic          sclk_q;
   logic          cs_n_q;
   logic          all_bits;

   assign all_bits  = (bits_q == LAST_BIT);
   assign busy      = (ph_q != PH_IDLE);
   assign load      = (ph_q == PH_IDLE) && start;
   assign sample_rx = (ph_q == PH_LOW) && tick;
   assign shift_tx  = (ph_q == PH_HIGH) && tick && !all_bits;
   assign finish    = (ph_q == PH_TAIL) && tick;
   assign commit    = finish && rd_q;
   assign sclk      = sclk_q;
   assign cs_n      = cs_n_q;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (start) ph_d = PH_LOW;
         PH_LOW:  if (tick)  ph_d = PH_HIGH;
         PH_HIGH: if (tick)  ph_d = all_bits ? PH_TAIL : PH_LOW;
         PH_TAIL: if (tick)  ph_d = PH_IDLE;
         default:            ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         bits_q <= '0;
         rd_q   <= 1'b0;
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         ph_q <= ph_d;
         if (load) begin
            bits_q <= '0;
            rd_q   <= op_read;
            cs_n_q <= 1'b0;
         end
         if (sample_rx) begin
            bits_q <= bits_q + 1'b1;
            sclk_q <= 1'b1;
         end
         if ((ph_q == PH_HIGH) && tick)
            sclk_q <= 1'b0;
         if (finish)
            cs_n_q <= 1'b1;
      end
   end

   AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R2

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !tick) |=> ($stable(ph_q) && $stable(bits_q))); // R9

   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q <= LAST_BIT); // R4

   AST_RELEASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> all_bits); // R4

endmodule

// File: rtl/spi_regacc_shift.sv
module spi_regacc_shift #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              op_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              shift_tx,
   input  logic              clear_tx,
   input  logic              sample_rx,
   input  logic              miso,
   input  logic              commit,
   output logic              mosi,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rd_valid
);
   localparam int unsigned FRAME = 1 + ADDR_W + DATA_W;

   logic [FRAME-1:0]  tx_q;
   logic [DATA_W-1:0] rx_q;
   logic [DATA_W-1:0] rd_byte_q;
   logic              rd_valid_q;

   assign mosi     = tx_q[FRAME-1];
   assign rd_byte  = rd_byte_q;
   assign rd_valid = rd_valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= {op_read, addr, wr_byte};
      else if (clear_tx)
         tx_q <= '0;
      else if (shift_tx)
         tx_q <= {tx_q[FRAME-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (sample_rx)
         rx_q <= {rx_q[DATA_W-2:0], miso};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_byte_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= commit;
         if (commit)
            rd_byte_q <= rx_q;
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R7

   AST_RDBYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> $stable(rd_byte)); // R8

   AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(shift_tx || sample_rx || commit)); // R9

endmodule

// File: rtl/spi_regacc_master.sv
module spi_regacc_master
   import spi_regacc_pkg::*;
#(
   parameter int unsigned DIV_RATIO = 40,
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_read_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wr_byte_i,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic [DATA_W-1:0] rd_byte_o,
   output logic              rd_valid_o
);
   localparam int unsigned HALF  = DIV_RATIO / 2;
   localparam int unsigned FRAME = frame_bits(ADDR_W, DATA_W);

   generate
      if ((DIV_RATIO < 4) || ((DIV_RATIO % 2) != 0)) begin : g_div_bad
         $error("spi_regacc_master: DIV_RATIO must be even and at least 4");
      end
      if ((ADDR_W < 1) || (DATA_W < 2)) begin : g_width_bad
         $error("spi_regacc_master: ADDR_W >= 1 and DATA_W >= 2 required");
      end
   endgenerate

   logic busy;
   logic tick;
   logic load;
   logic sample_rx;
   logic shift_tx;
   logic finish;
   logic commit;

   spi_regacc_div #(
      .HALF (HALF)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   spi_regacc_seq #(
      .FRAME (FRAME)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_i),
      .op_read   (op_read_i),
      .tick      (tick),
      .busy      (busy),
      .load      (load),
      .sample_rx (sample_rx),
      .shift_tx  (shift_tx),
      .finish    (finish),
      .commit    (commit),
      .sclk      (sclk_o),
      .cs_n      (cs_n_o)
   );

   spi_regacc_shift #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .op_read   (op_read_i),
      .addr      (addr_i),
      .wr_byte   (wr_byte_i),
      .shift_tx  (shift_tx),
      .clear_tx  (finish),
      .sample_rx (sample_rx),
      .miso      (miso_i),
      .commit    (commit),
      .mosi      (mosi_o),
      .rd_byte   (rd_byte_o),
      .rd_valid  (rd_valid_o)
   );

   AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R5

   AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $rose(cs_n_o)); // R7

   AST_CS_FALL_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> !sclk_o); // R3

endmodule

// File: tb/spi_regacc_master_test.sv
`timescale 1ns/1ps
module spi_regacc_master_test;
   localparam int DIV = 4;
   localparam int H   = DIV / 2;
   localparam int NB  = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic       op_rd;
   logic [6:0] addr;
   logic [7:0] wdata;
   logic       miso;
   logic       sclk, cs_n, mosi, rd_valid;
   logic [7:0] rd_byte;

   int checks = 0;
   int errors = 0;

   spi_regacc_master #(.DIV_RATIO(DIV), .ADDR_W(7), .DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_read_i(op_rd),
      .addr_i(addr), .wr_byte_i(wdata), .sclk_o(sclk), .cs_n_o(cs_n),
      .mosi_o(mosi), .miso_i(miso), .rd_byte_o(rd_byte), .rd_valid_o(rd_valid)
   );

   initial forever #5 clk = ~clk;

   // slave model: four registers at addresses 0..3, others read as zero
   logic [7:0]  sl_reg [4];
   logic [15:0] sl_frm, sl_last;
   logic [7:0]  sl_out;
   logic        sl_cs, sl_ck, sl_rd;
   int          sl_n;
   initial begin
      miso = 1'b0; sl_cs = 1'b1; sl_ck = 1'b0; sl_frm = '0; sl_last = '0;
      sl_out = '0; sl_rd = 1'b0; sl_n = 0;
      for (int i = 0; i < 4; i++) sl_reg[i] = '0;
      forever begin
         @(sclk or cs_n);
         if (cs_n !== sl_cs) begin
            sl_cs = cs_n;
            if (!cs_n) begin
               sl_n = 0; sl_frm = '0; sl_rd = 1'b0;
            end else begin
               if (!sl_frm[15] && sl_frm[14:8] < 7'd4) sl_reg[sl_frm[9:8]] = sl_frm[7:0];
               sl_last = sl_frm;
               miso = 1'b0;
            end
         end
         if (sclk !== sl_ck) begin
            sl_ck = sclk;
            if (sclk) begin
               sl_frm = {sl_frm[14:0], mosi};
               sl_n++;
            end else if (sl_n == 8) begin
               sl_rd  = sl_frm[7];
               sl_out = (sl_frm[6:0] < 7'd4) ? sl_reg[sl_frm[1:0]] : 8'h00;
               if (sl_rd) miso = sl_out[7];
            end else if (sl_n > 8 && sl_n < 16 && sl_rd) begin
               sl_out = {sl_out[6:0], 1'b0};
               miso   = sl_out[7];
            end
         end
      end
   end

   // monitor, sampled away from the active edge
   int m_starts = 0, m_ends = 0, m_low = 0, m_rises = 0, m_lead = 0;
   int m_vcnt = 0, m_vlong = 0, m_vmis = 0, m_idle_bad = 0;
   logic pcs = 1'b1, psclk = 1'b0, pv = 1'b0, lead_open = 1'b0;
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (pcs && !cs_n) begin
            m_starts++; m_low = 0; m_rises = 0; m_lead = 0; lead_open = 1'b1;
         end
         if (!cs_n) m_low++;
         if (sclk && !psclk) begin m_rises++; lead_open = 1'b0; end
         if (lead_open && !cs_n) m_lead++;
         if (!pcs && cs_n) m_ends++;
         if (cs_n && sclk) m_idle_bad++;
         if (rd_valid) begin
            m_vcnt++;
            if (pv) m_vlong++;
            if (!(cs_n && !pcs)) m_vmis++;
         end
      end
      pcs = cs_n; psclk = sclk; pv = rd_valid;
   end

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   logic [7:0] exp_reg [4];
   logic [7:0] last_rd = 8'h00;

   task automatic check_idle(input string tag);
      chk(cs_n == 1'b1, {tag, " cs_n"}, cs_n, 1);
      chk(sclk == 1'b0, {tag, " sclk"}, sclk, 0);
      chk(mosi == 1'b0, {tag, " mosi"}, mosi, 0);
      chk(rd_valid == 1'b0, {tag, " rd_valid"}, rd_valid, 0);
      chk(rd_byte == 8'h00, {tag, " rd_byte"}, rd_byte, 0);
   endtask

   task automatic pulse_start(input logic op, input logic [6:0] a, input logic [7:0] d);
      @(negedge clk); start = 1'b1; op_rd = op; addr = a; wdata = d;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run_frame(input logic op, input logic [6:0] a, input logic [7:0] d);
      int v0 = m_vcnt;
      logic [7:0] expv;
      pulse_start(op, a, d);
      while (!cs_n) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(m_lead == H, "R3 lead cycles", m_lead, H);
      chk(m_rises == NB, "R4 sclk rises", m_rises, NB);
      chk(m_low == (2 * NB + 1) * H, "R4 cs low cycles", m_low, (2 * NB + 1) * H);
      chk(sl_last == {op, a, d}, "R5 mosi frame", sl_last, {op, a, d});
      if (op) begin
         expv = (a < 7'd4) ? exp_reg[a[1:0]] : 8'h00;
         chk(rd_byte == expv, "R6 read byte", rd_byte, expv);
         chk(m_vcnt == v0 + 1, "R7 one strobe", m_vcnt - v0, 1);
         last_rd = expv;
      end else begin
         if (a < 7'd4) exp_reg[a[1:0]] = d;
         chk(m_vcnt == v0, "R8 no strobe", m_vcnt - v0, 0);
         chk(rd_byte == last_rd, "R8 byte held", rd_byte, last_rd);
      end
   endtask

   initial begin
      int s0, v0;
      for (int i = 0; i < 4; i++) exp_reg[i] = '0;
      rst_n = 1'b0; start = 1'b0; op_rd = 1'b0; addr = '0; wdata = '0;
      repeat (4) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_idle("R1 after reset");

      // data sweep: every byte value written and read back
      for (int v = 0; v < 256; v++) begin
         run_frame(1'b0, 7'(v % 4), 8'((v * 29 + 7) & 255));
         run_frame(1'b1, 7'(v % 4), 8'(v ^ 8'h5A));
      end
      // address sweep over all reads
      for (int a = 0; a < 128; a++) run_frame(1'b1, 7'(a), 8'(a ^ 8'hC3));

      // R9: start pulse in the middle of a frame
      s0 = m_starts;
      pulse_start(1'b0, 7'd2, 8'h3C);
      repeat (10) @(negedge clk);
      start = 1'b1; op_rd = 1'b1; addr = 7'd5; wdata = 8'hFF;
      @(negedge clk); start = 1'b0;
      while (!cs_n) @(negedge clk);
      repeat (6) @(negedge clk);
      exp_reg[2] = 8'h3C;
      chk(m_starts == s0 + 1, "R9 mid-frame start ignored", m_starts - s0, 1);
      chk(sl_last == {1'b0, 7'd2, 8'h3C}, "R9 frame unchanged", sl_last, {1'b0, 7'd2, 8'h3C});

      // R9/R7: start pulse on the final edge of a read frame
      s0 = m_starts; v0 = m_vcnt;
      @(negedge clk); start = 1'b1; op_rd = 1'b1; addr = 7'd2; wdata = 8'h00;
      @(negedge clk); start = 1'b0;
      chk(cs_n == 1'b0, "R3 cs low after start", cs_n, 0);
      repeat ((2 * NB + 1) * H - 1) @(negedge clk);
      start = 1'b1; op_rd = 1'b0; addr = 7'd3; wdata = 8'h77;
      @(negedge clk); start = 1'b0;
      chk(cs_n == 1'b1 && rd_valid == 1'b1, "R7 strobe at release", {cs_n, rd_valid}, 3);
      chk(rd_byte == 8'h3C, "R6 byte at collision", rd_byte, 8'h3C);
      repeat (12) @(negedge clk);
      chk(cs_n == 1'b1, "R9 end-cycle start ignored", cs_n, 1);
      chk(m_starts == s0 + 1, "R9 single frame", m_starts - s0, 1);
      chk(m_vcnt == v0 + 1, "R7 single strobe", m_vcnt - v0, 1);

      chk(m_vlong == 0, "R7 strobe width", m_vlong, 0);
      chk(m_vmis == 0, "R7 strobe alignment", m_vmis, 0);
      chk(m_idle_bad == 0, "R2 idle sclk low", m_idle_bad, 0);

      // R1: reset in the middle of a frame
      pulse_start(1'b1, 7'd1, 8'h00);
      repeat (9) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R1 reset mid-frame");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule